// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block sits beside an SRAM port and watches every bus cycle it is shown. A bus cycle arrives as a strobe (`cyc_valid`) together with an address and the level of the active-low write enable. The block waits for six consecutive read cycles whose addresses form a fixed chain. When the chain is complete it asks for a transfer between the SRAM and its nonvolatile shadow. The first five links are the same for both commands. The sixth address decides whether the request is a save to nonvolatile storage or a restore from it.

Only the low 14 address bits take part in the comparison, and any higher bits are ignored. A write cycle, an address outside the chain, or a link taken out of order discards the progress made so far. Clock cycles without a strobe leave the progress unchanged. The block has no output-enable input, so recognition cannot depend on that level. It drives no data pins: the reads in the chain are ordinary SRAM reads, handled elsewhere. Each request leaves the block as a registered pulse one clock wide.

Top module: `nvseq_detect`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives both request outputs low and discards any partial chain, so a chain completed after the reset must be entered again from its first link.
- R2: Six strobed reads with `cyc_we_n` high, at addresses 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0 in that order, raise `store_req` for the clock that follows the edge sampling the sixth read.
- R3: The same first five reads followed by a read at 0x0C63 raise `recall_req` with the same timing as R2.
- R4: Address bits at position 14 and above are ignored: a chain whose addresses also have bit 14 set is recognised exactly as in R2 and R3.
- R5: A strobed cycle with `cyc_we_n` low, at any point within a chain, discards the progress, and the remaining links then produce no request.
- R6: A strobed read whose address is not the next expected link discards the progress. If that address equals 0x0E38, it counts as the first link of a new chain.
- R7: Clock cycles with `cyc_valid` low change neither the progress nor the outputs, so idle gaps between links do not break a chain.
- R8: Each request is high for exactly one clock, and the detector then starts from an empty chain. A repeated sixth address straight after a request produces nothing.
- R9: `store_req` and `recall_req` are never high in the same clock.
- R10: The six links taken in any other order, for example with two adjacent links swapped, produce no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cyc_valid | input | 1 | High for each clock that carries a bus cycle |
| cyc_we_n | input | 1 | Write enable, active low; high marks a read cycle |
| cyc_addr | input | ADDR_W (15) | Address of the bus cycle |
| store_req | output | 1 | One-clock request to copy the SRAM into nonvolatile storage |
| recall_req | output | 1 | One-clock request to restore the SRAM from nonvolatile storage |

## Verification
Each request passes through one register. It is due in the clock straight after the edge that samples the sixth read, and it is gone one clock later. The bench drives each bus cycle at a falling edge and compares the outputs at the following falling edge. Every comparison therefore falls half a period after the one edge at which the result is allowed to change. The expected value comes from a separate model that keeps the last six read addresses and is updated as each cycle is driven, so every cycle of every sweep is checked for both outputs, including the clocks where no request may appear.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  localparam int KEY_W   = 14;
  localparam int SEQ_LEN = 6;
  localparam int STEP_W  = $clog2(SEQ_LEN);

  localparam logic [KEY_W-1:0] TAIL_STORE  = 14'h0FC0;
  localparam logic [KEY_W-1:0] TAIL_RECALL = 14'h0C63;

  // Shared links of the chain; index 0 is the entry link.
  function automatic logic [KEY_W-1:0] chain_link(input int idx);
    logic [KEY_W-1:0] v;
    case (idx)
      0:       v = 14'h0E38;
      1:       v = 14'h31C7;
      2:       v = 14'h03E0;
      3:       v = 14'h3C1F;
      4:       v = 14'h303F;
      default: v = '0;
    endcase
    return v;
  endfunction

  // Progress after a read: advance on the expected link, re-enter on the
  // entry link, otherwise fall back to empty. At the last link the chain
  // either completes (empty afterwards) or restarts.
  function automatic logic [STEP_W-1:0] step_advance(
    input logic [STEP_W-1:0] cur,
    input logic              cur_hit,
    input logic              entry_hit,
    input logic              at_last
  );
    logic [STEP_W-1:0] n;
    if (!at_last && cur_hit)  n = cur + 1'b1;
    else if (entry_hit)       n = STEP_W'(1);
    else                      n = '0;
    return n;
  endfunction

endpackage

// File: rtl/nvseq_link_match.sv
module nvseq_link_match
  import nvseq_pkg::*;
#(
  parameter int LINKS = SEQ_LEN - 1
) (
  input  logic [KEY_W-1:0] key_addr,
  output logic [LINKS-1:0] link_hit,
  output logic             tail_store_hit,
  output logic             tail_recall_hit
);

  for (genvar i = 0; i < LINKS; i++) begin : g_link
    assign link_hit[i] = (key_addr == chain_link(i));
  end

  assign tail_store_hit  = (key_addr == TAIL_STORE);
  assign tail_recall_hit = (key_addr == TAIL_RECALL);

endmodule

// File: rtl/nvseq_progress.sv
module nvseq_progress
  import nvseq_pkg::*;
#(
  parameter int LINKS = SEQ_LEN - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_evt,
  input  logic              wr_evt,
  input  logic [LINKS-1:0]  link_hit,
  output logic [STEP_W-1:0] step,
  output logic              at_last
);

  logic              cur_hit;
  logic [STEP_W-1:0] step_nxt;

  assign at_last = (step == STEP_W'(LINKS));
  assign cur_hit = at_last ? 1'b0 : link_hit[step];

  always_comb begin
    step_nxt = step;
    if (wr_evt)      step_nxt = '0;
    else if (rd_evt) step_nxt = step_advance(step, cur_hit, link_hit[0], at_last);
  end

  always_ff @(posedge clk) begin
    if (rst) step <= '0;
    else     step <= step_nxt;
  end

  // R5: a write leaves no progress behind
  a_r5_write_clears: assert property (@(posedge clk) disable iff (rst)
    wr_evt |=> (step == '0));

  // R7: no strobe, no movement
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !(rd_evt || wr_evt) |=> $stable(step));

  // R6: an off-chain entry link restarts at one
  a_r6_entry_restart: assert property (@(posedge clk) disable iff (rst)
    (rd_evt && link_hit[0]) |=> (step == STEP_W'(1)));

  // R10: progress never runs past the last link
  a_r10_step_range: assert property (@(posedge clk) disable iff (rst)
    step <= STEP_W'(LINKS));

endmodule

// File: rtl/nvseq_req_out.sv
module nvseq_req_out (
  input  logic clk,
  input  logic rst,
  input  logic fire_store,
  input  logic fire_recall,
  output logic store_req,
  output logic recall_req
);

  always_ff @(posedge clk) begin
    if (rst) begin
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      store_req  <= fire_store;
      recall_req <= fire_recall;
    end
  end

  // R9: never both requests together
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(store_req && recall_req));

  // R8: each request lasts one clock
  a_r8_store_single: assert property (@(posedge clk) disable iff (rst)
    store_req |=> !store_req);
  a_r8_recall_single: assert property (@(posedge clk) disable iff (rst)
    recall_req |=> !recall_req);

endmodule

// File: rtl/nvseq_detect.sv
module nvseq_detect
  import nvseq_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_valid,
  input  logic              cyc_we_n,
  input  logic [ADDR_W-1:0] cyc_addr,
  output logic              store_req,
  output logic              recall_req
);

  localparam int LINKS = SEQ_LEN - 1;

  logic [KEY_W-1:0]  key_addr;
  logic              unused_upper;
  logic              rd_evt, wr_evt;
  logic [LINKS-1:0]  link_hit;
  logic              tail_store_hit, tail_recall_hit;
  logic [STEP_W-1:0] step;
  logic              at_last;
  logic              fire_store, fire_recall;

  assign key_addr     = cyc_addr[KEY_W-1:0];
  assign unused_upper = ^cyc_addr[ADDR_W-1:KEY_W];
  assign rd_evt       = cyc_valid &  cyc_we_n;
  assign wr_evt       = cyc_valid & ~cyc_we_n;

  nvseq_link_match #(.LINKS(LINKS)) u_match (
    .key_addr       (key_addr),
    .link_hit       (link_hit),
    .tail_store_hit (tail_store_hit),
    .tail_recall_hit(tail_recall_hit)
  );

  nvseq_progress #(.LINKS(LINKS)) u_prog (
    .clk     (clk),
    .rst     (rst),
    .rd_evt  (rd_evt),
    .wr_evt  (wr_evt),
    .link_hit(link_hit),
    .step    (step),
    .at_last (at_last)
  );

  assign fire_store  = rd_evt & at_last & tail_store_hit;
  assign fire_recall = rd_evt & at_last & tail_recall_hit;

  nvseq_req_out u_out (
    .clk        (clk),
    .rst        (rst),
    .fire_store (fire_store),
    .fire_recall(fire_recall),
    .store_req  (store_req),
    .recall_req (recall_req)
  );

  // R2: a store request only follows a completed chain read
  a_r2_store_origin: assert property (@(posedge clk) disable iff (rst)
    store_req |-> $past(rd_evt && at_last));

  // R3: a recall request only follows a completed chain read
  a_r3_recall_origin: assert property (@(posedge clk) disable iff (rst)
    recall_req |-> $past(rd_evt && at_last));

  // R8: after any request the chain starts empty
  a_r8_empty_after: assert property (@(posedge clk) disable iff (rst)
    (store_req || recall_req) |-> (step <= STEP_W'(1)));

endmodule

// File: tb/sim_nvseq_detect.sv
module sim_nvseq_detect;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_valid = 1'b0;
  logic        cyc_we_n = 1'b1;
  logic [14:0] cyc_addr = '0;
  logic        store_req, recall_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nvseq_detect u0 (.*);

  // Chain: entries 0..4 shared, 5 = save tail, 6 = restore tail.
  logic [13:0] seq [7] = '{14'h0E38, 14'h31C7, 14'h03E0, 14'h3C1F,
                           14'h303F, 14'h0FC0, 14'h0C63};

  // Reference: last six reads since the last write/reset/request.
  logic [13:0] hist [6];
  int          hcnt = 0;
  logic        exp_st = 0, exp_rc = 0;

  function automatic bit hist_is(input int tail);
    bit ok = 1;
    for (int i = 0; i < 5; i++) if (hist[i] != seq[i]) ok = 0;
    if (hist[5] != seq[tail]) ok = 0;
    return ok;
  endfunction

  task automatic check(input logic got, input logic exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", tag, got, exp, $time);
    end
  endtask

  // Drive one clock at a falling edge, update the reference, compare at the next.
  task automatic cyc(input bit v, input bit we_n, input logic [14:0] a, input string tag);
    cyc_valid = v; cyc_we_n = we_n; cyc_addr = a;
    exp_st = 0; exp_rc = 0;
    if (v && !we_n) hcnt = 0;
    else if (v) begin
      for (int i = 0; i < 5; i++) hist[i] = hist[i+1];
      hist[5] = a[13:0];
      if (hcnt < 6) hcnt++;
      if (hcnt == 6 && hist_is(5)) begin exp_st = 1; hcnt = 0; end
      else if (hcnt == 6 && hist_is(6)) begin exp_rc = 1; hcnt = 0; end
    end
    @(negedge clk);
    check(store_req, exp_st, {tag, " store"});
    check(recall_req, exp_rc, {tag, " recall"});
  endtask

  task automatic rd(input logic [14:0] a, input string tag);
    cyc(1, 1, a, tag);
  endtask

  task automatic chain(input int tail, input logic [14:0] hi, input string tag);
    for (int i = 0; i < 5; i++) rd(hi | 15'(seq[i]), tag);
    rd(hi | 15'(seq[tail]), tag);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    end
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    @(negedge clk); @(negedge clk);
    check(store_req, 0, "R1 reset");
    check(recall_req, 0, "R1 reset");
    rst = 0; hcnt = 0;

    chain(5, 15'h0, "R2");
    chain(6, 15'h0, "R3");
    chain(5, 15'h4000, "R4");
    chain(6, 15'h4000, "R4");

    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < k; i++) rd(15'(seq[i]), "R5");
      cyc(1, 0, 15'(seq[k]), "R5 write");
      for (int i = k; i < 6; i++) rd(15'(seq[i]), "R5");
    end

    for (int k = 1; k < 6; k++) begin
      for (int i = 0; i < k; i++) rd(15'(seq[i]), "R6");
      rd(15'h1234, "R6 stray");
      for (int i = k; i < 6; i++) rd(15'(seq[i]), "R6");
      for (int i = 0; i < k; i++) rd(15'(seq[i]), "R6");
      chain(6, 15'h0, "R6 reentry");
    end

    for (int i = 0; i < 6; i++) begin
      rd(15'(seq[i]), "R7");
      for (int g = 0; g < i + 1; g++) cyc(0, g[0], 15'h7FFF, "R7 idle");
    end

    chain(5, 15'h0, "R8");
    rd(15'(seq[5]), "R8 repeat");
    rd(15'(seq[6]), "R8 repeat");
    chain(6, 15'h0, "R8");

    for (int s = 0; s < 5; s++) begin
      for (int i = 0; i < 6; i++)
        rd(15'(seq[i == s ? s + 1 : (i == s + 1 ? s : i)]), "R10 swap");
    end

    for (int i = 0; i < 5; i++) rd(15'(seq[i]), "R1");
    rst = 1; hcnt = 0;
    @(negedge clk);
    check(store_req, 0, "R1 mid reset");
    rst = 0;
    rd(15'(seq[5]), "R1 after reset");
    chain(5, 15'h0, "R1 after reset");

    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[3:0])
        4'd0:    cyc(1, 0, 15'(lfsr), "R9 sweep");
        4'd1:    cyc(0, 1, 15'(lfsr), "R9 sweep");
        4'd2:    rd(15'(lfsr), "R9 sweep");
        4'd3:    chain(5 + int'(lfsr[4]), {lfsr[5], 14'h0}, "R9 sweep");
        default: rd({lfsr[6], 14'h0} | 15'(seq[int'(lfsr[10:8]) % 7]), "R9 sweep");
      endcase
    end

    cyc(0, 1, 15'h0, "R8 tail");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule